// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests from eleven sources and offers at most one of them to a processor core at a time. The sources are two timer overflows, four external lines (two sensed by level, two by falling edge), a watchdog timeout, a serial-port event, a divider overflow, a comparator rising edge and a caller-ID group. The caller-ID group is the OR of six sticky sub-flags. Each source has an enable bit and a priority bit that selects the high or the low level. A global enable gates every source.

The controller presents a registered request and a 4-bit vector index. When the core accepts, it pulses `irq_ack`. The controller records the accepted level in a two-bit in-service stack. It also clears the source's flag when that source clears on acknowledge. The core pulses `irq_ret` when its handler ends, and the highest in-service level is then released. A request is offered only when its level is strictly above the highest level in service. So a low handler can be interrupted by a high request, but a high handler cannot be interrupted.

Top module: `intc_two_level`

## Requirements
- R1: While `en_main[7]` (global enable) is 0, `irq_req` is 0 on the cycle after the value is seen, whatever is pending. Raising it lets pending, enabled requests through.
- R2: Per-source enables: `en_main` bits 0..4 enable ext0, timer0, ext1, timer1 and serial. `en_ext` bits 0..5 enable ext2, ext3, divider, comparator, caller-ID and watchdog. A disabled source is not offered, but its flag is kept.
- R3: `prio[i]` = 1 puts the source with vector i at the high level. An eligible high-level source is offered before any low-level one, whatever their order.
- R4: Within one level the lowest vector wins. Vector codes are ext0=0, timer0=1, ext1=2, timer1=3, serial=4, ext2=5, ext3=6, watchdog=7, divider=8, comparator=9, caller-ID=10.
- R5: `irq_ack` while `irq_req`=1 sets the in-service bit of the offered level (`in_svc` bit 1 = high, bit 0 = low). A request is offered only if its level is strictly above the highest in-service level.
- R6: A pulse on `irq_ret` clears the highest set bit of `in_svc`.
- R7: `irq_req` is 0 on the cycle after an accepted `irq_ack`. Timer, serial, ext2, ext3, divider and comparator flags clear on their acknowledge.
- R8: ext0 and ext1 (`ext_n[0]`, `ext_n[1]`) are pending while their input is low. If the input is still low after the return, the source is offered again. They have no flag.
- R9: ext2 and ext3 set a flag only on a 1-to-0 change of `ext_n[2]`/`ext_n[3]`. Holding the input low or raising it sets nothing.
- R10: The comparator flag sets only on a 0-to-1 change of `cmp_res`. A result that stays high sets nothing.
- R11: The watchdog flag is set by `wdt_tmo`. It is not cleared by acknowledge, only by `wdt_clr`.
- R12: Caller-ID sub-flags (`cid_flags`) set from `cid_set` and clear only from `cid_clr`. A set wins over a clear in the same cycle. The caller-ID request is their OR, and acknowledge does not clear it.
- R13: After reset, `irq_req`, `in_svc` and `cid_flags` are 0. An event pulse seen at clock edge k gives `irq_req`=1 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 4 | Active-low external lines; 0,1 level, 2,3 falling edge |
| tmr_ovf | input | 2 | Timer 1/0 overflow pulses |
| ser_evt | input | 1 | Serial event pulse |
| div_ovf | input | 1 | Divider overflow pulse |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| wdt_clr | input | 1 | Software clear of the watchdog flag |
| cmp_res | input | 1 | Real-time comparator result |
| cid_set | input | 6 | Caller-ID sub-flag set pulses |
| cid_clr | input | 6 | Caller-ID sub-flag software clear |
| en_main | input | 8 | Enables: bit 7 global, bits 0..4 per source |
| en_ext | input | 8 | Enables: bits 0..5 per source |
| prio | input | 11 | Level per vector, 1 = high |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_ret | input | 1 | Core ends the current handler |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | 4 | Registered vector index, valid with irq_req |
| in_svc | output | 2 | In-service levels, bit 1 high, bit 0 low |
| cid_flags | output | 6 | Caller-ID sub-flags |

## Verification
Most faults in the flags or the in-service stack reach the ports within two cycles. A flag left set after its acknowledge brings the request back one cycle after the return. A missed edge or a wrong level bit gives a different `irq_vec` on the next offer. A stack that releases the wrong level lets a low request through under a high handler, or keeps a nested low handler blocked. Both cases show on `irq_req` and `in_svc` one cycle after the return. A behavioural model in the bench follows every clock, so such a mismatch is reported on the first cycle it shows.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 11;
  localparam int CID_W = 6;
  localparam int NEXT  = 4;
  localparam int NLVL  = 2;
  localparam int VEC_W = $clog2(NSRC);

  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_EXT2 = 5;
  localparam int SRC_EXT3 = 6;
  localparam int SRC_WDT  = 7;
  localparam int SRC_DIV  = 8;
  localparam int SRC_CMP  = 9;
  localparam int SRC_CID  = 10;

  typedef logic [NSRC-1:0] src_vec_t;

  // sources whose flag drops when their vector is accepted
  localparam src_vec_t AUTO_CLR = src_vec_t'((1 << SRC_TMR0) | (1 << SRC_TMR1) |
                                  (1 << SRC_SER) | (1 << SRC_EXT2) | (1 << SRC_EXT3) |
                                  (1 << SRC_DIV) | (1 << SRC_CMP));
  // sources whose request is not a flag of this table
  localparam src_vec_t NOFLAG = src_vec_t'((1 << SRC_EXT0) | (1 << SRC_EXT1) | (1 << SRC_CID));
endpackage

// File: rtl/intc_capture.sv
module intc_capture
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_evt,
  input  logic             div_ovf,
  input  logic             wdt_tmo,
  input  logic             wdt_clr,
  input  logic             cmp_res,
  input  logic [CID_W-1:0] cid_set,
  input  logic [CID_W-1:0] cid_clr,
  input  logic             ack_stb,
  input  logic [VEC_W-1:0] ack_idx,
  output src_vec_t         pend,
  output logic [CID_W-1:0] cid_flags
);
  logic [NEXT-1:0]  ext_q;
  logic             cmp_q;
  src_vec_t         fl;
  src_vec_t         set_v;
  src_vec_t         clr_v;
  src_vec_t         ack_1h;
  src_vec_t         lvl_v;
  logic [CID_W-1:0] cid_r;

  // input history for edge detection, captured also during reset
  always_ff @(posedge clk) begin
    ext_q <= ext_n;
    cmp_q <= cmp_res;
  end

  always_comb begin
    set_v = '0;
    set_v[SRC_TMR0] = tmr_ovf[0];
    set_v[SRC_TMR1] = tmr_ovf[1];
    set_v[SRC_SER]  = ser_evt;
    set_v[SRC_EXT2] = ext_q[2] & ~ext_n[2];
    set_v[SRC_EXT3] = ext_q[3] & ~ext_n[3];
    set_v[SRC_WDT]  = wdt_tmo;
    set_v[SRC_DIV]  = div_ovf;
    set_v[SRC_CMP]  = cmp_res & ~cmp_q;
    ack_1h = ack_stb ? (src_vec_t'(1) << ack_idx) : '0;
    clr_v  = (ack_1h & AUTO_CLR) | (src_vec_t'(wdt_clr) << SRC_WDT);
  end

  always_ff @(posedge clk) begin
    if (rst) fl <= '0;
    else     fl <= ((fl & ~clr_v) | set_v) & ~NOFLAG;
  end

  genvar g;
  generate
    for (g = 0; g < CID_W; g++) begin : g_cid
      always_ff @(posedge clk) begin
        if (rst)             cid_r[g] <= 1'b0;
        else if (cid_set[g]) cid_r[g] <= 1'b1;
        else if (cid_clr[g]) cid_r[g] <= 1'b0;
      end
      // R12: a sub-flag survives every cycle without a software clear
      a_r12_cid_sticky: assert property (@(posedge clk) disable iff (rst)
        cid_r[g] && !cid_clr[g] |=> cid_r[g]);
    end
  endgenerate

  always_comb begin
    lvl_v = '0;
    lvl_v[SRC_EXT0] = ~ext_q[0];
    lvl_v[SRC_EXT1] = ~ext_q[1];
    lvl_v[SRC_CID]  = |cid_r;
  end

  assign pend      = (fl & ~NOFLAG) | lvl_v;
  assign cid_flags = cid_r;

  // R10: a comparator flag rises only after a 0-to-1 change of the result
  a_r10_cmp_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(fl[SRC_CMP]) |-> $past(cmp_res) && !$past(cmp_res, 2));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [N-1:0]  hi_mask,
  output logic          win_v,
  output logic          win_hi,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0]  hi_c;
  logic [N-1:0]  use_c;
  logic [IW-1:0] idx;

  assign hi_c   = elig & hi_mask;
  assign win_hi = |hi_c;
  assign use_c  = win_hi ? hi_c : elig;
  assign win_v  = |elig;

  // lowest set position wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (use_c[i]) idx = IW'(i);
  end
  assign win_idx = idx;
endmodule

// File: rtl/intc_svc_stack.sv
module intc_svc_stack
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_stb,
  input  logic            ack_hi,
  input  logic            ret,
  output logic [NLVL-1:0] ins
);
  logic [NLVL-1:0] nxt;
  logic            done;

  always_comb begin
    nxt  = ins;
    done = 1'b0;
    if (ret)
      for (int l = NLVL - 1; l >= 0; l--)
        if (!done && nxt[l]) begin
          nxt[l] = 1'b0;
          done   = 1'b1;
        end
    if (ack_stb) nxt[ack_hi ? 1 : 0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ins <= '0;
    else     ins <= nxt;
  end

  // R6: return releases the high level first, then the low one
  a_r6_ret_high: assert property (@(posedge clk) disable iff (rst)
    ret && !ack_stb && ins[NLVL-1] |=> !ins[NLVL-1] && ins[0] == $past(ins[0]));
  a_r6_ret_low: assert property (@(posedge clk) disable iff (rst)
    ret && !ack_stb && ins == NLVL'(1) |=> ins == '0);
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  ext_n,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_evt,
  input  logic        div_ovf,
  input  logic        wdt_tmo,
  input  logic        wdt_clr,
  input  logic        cmp_res,
  input  logic [5:0]  cid_set,
  input  logic [5:0]  cid_clr,
  input  logic [7:0]  en_main,
  input  logic [7:0]  en_ext,
  input  logic [10:0] prio,
  input  logic        irq_ack,
  input  logic        irq_ret,
  output logic        irq_req,
  output logic [3:0]  irq_vec,
  output logic [1:0]  in_svc,
  output logic [5:0]  cid_flags
);
  src_vec_t         pend;
  src_vec_t         en;
  src_vec_t         elig;
  logic             win_v;
  logic             win_hi;
  logic [VEC_W-1:0] win_idx;
  logic             can_take;
  logic             ack_stb;
  logic             unused_en;

  assign ack_stb = irq_ack & irq_req;

  intc_capture u_cap (
    .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_evt(ser_evt),
    .div_ovf(div_ovf), .wdt_tmo(wdt_tmo), .wdt_clr(wdt_clr), .cmp_res(cmp_res),
    .cid_set(cid_set), .cid_clr(cid_clr), .ack_stb(ack_stb), .ack_idx(irq_vec),
    .pend(pend), .cid_flags(cid_flags)
  );

  always_comb begin
    en = '0;
    en[SRC_EXT0] = en_main[0];
    en[SRC_TMR0] = en_main[1];
    en[SRC_EXT1] = en_main[2];
    en[SRC_TMR1] = en_main[3];
    en[SRC_SER]  = en_main[4];
    en[SRC_EXT2] = en_ext[0];
    en[SRC_EXT3] = en_ext[1];
    en[SRC_DIV]  = en_ext[2];
    en[SRC_CMP]  = en_ext[3];
    en[SRC_CID]  = en_ext[4];
    en[SRC_WDT]  = en_ext[5];
  end
  assign unused_en = ^{en_main[6:5], en_ext[7:6]};
  assign elig      = pend & en & {NSRC{en_main[7]}};

  intc_arbiter #(.N(NSRC)) u_arb (
    .elig(elig), .hi_mask(prio), .win_v(win_v), .win_hi(win_hi), .win_idx(win_idx)
  );

  intc_svc_stack u_stk (
    .clk(clk), .rst(rst), .ack_stb(ack_stb), .ack_hi(prio[irq_vec]),
    .ret(irq_ret), .ins(in_svc)
  );

  // strictly above the highest level in service
  assign can_take = win_v && (win_hi ? !in_svc[1] : (in_svc == 2'b00));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (ack_stb) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= can_take;
      irq_vec <= win_idx;
    end
  end

  // R1: global enable low blocks the next offer
  a_r1_global_off: assert property (@(posedge clk) disable iff (rst)
    !$past(en_main[7]) |-> !irq_req);
  // R5: nothing is offered while a high-level handler runs
  a_r5_no_req_under_high: assert property (@(posedge clk) disable iff (rst)
    in_svc[1] |-> !irq_req);
  // R7: an accepted acknowledge withdraws the request
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    irq_ack && irq_req |=> !irq_req);
  // R5: acknowledge marks a level in service
  a_r5_ack_marks: assert property (@(posedge clk) disable iff (rst)
    irq_ack && irq_req && !irq_ret |=> in_svc != 2'b00);
endmodule

// File: tb/sim_intc_two_level.sv
module sim_intc_two_level;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ext_n = 4'hF;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_evt = 0, div_ovf = 0, wdt_tmo = 0, wdt_clr = 0, cmp_res = 0;
  logic [5:0]  cid_set = '0, cid_clr = '0;
  logic [7:0]  en_main = 8'h9F, en_ext = 8'h3F;
  logic [10:0] prio = '0;
  logic        irq_ack = 0, irq_ret = 0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [1:0]  in_svc;
  logic [5:0]  cid_flags;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  intc_two_level u0 (
    .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_evt(ser_evt),
    .div_ovf(div_ovf), .wdt_tmo(wdt_tmo), .wdt_clr(wdt_clr), .cmp_res(cmp_res),
    .cid_set(cid_set), .cid_clr(cid_clr), .en_main(en_main), .en_ext(en_ext),
    .prio(prio), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .irq_vec(irq_vec), .in_svc(in_svc), .cid_flags(cid_flags)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit [3:0]  m_eq;
  bit        m_cq;
  bit [10:0] m_fl;
  bit [5:0]  m_cid;
  bit [1:0]  m_ins;
  bit        m_req;
  int        m_vec;
  bit [10:0] m_pend;
  int        w;
  bit        whi, take, ackv, alvl;
  int        av;

  function automatic bit en_of(input int i);
    case (i)
      0: return en_main[0];  1: return en_main[1];
      2: return en_main[2];  3: return en_main[3];
      4: return en_main[4];  5: return en_ext[0];
      6: return en_ext[1];   7: return en_ext[5];
      8: return en_ext[2];   9: return en_ext[3];
      default: return en_ext[4];
    endcase
  endfunction

  function automatic bit auto_clr(input int i);
    return i == 1 || i == 3 || i == 4 || i == 5 || i == 6 || i == 8 || i == 9;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fl = '0; m_cid = '0; m_ins = '0; m_req = 0; m_vec = 0;
    end else begin
      for (int i = 0; i < 11; i++) m_pend[i] = m_fl[i];
      m_pend[0]  = !m_eq[0];
      m_pend[2]  = !m_eq[1];
      m_pend[10] = |m_cid;
      w = -1;
      for (int i = 0; i < 11; i++)
        if (w < 0 && m_pend[i] && en_of(i) && en_main[7] && prio[i]) w = i;
      for (int i = 0; i < 11; i++)
        if (w < 0 && m_pend[i] && en_of(i) && en_main[7]) w = i;
      whi  = (w >= 0) && prio[w];
      take = (w >= 0) && (whi ? !m_ins[1] : (m_ins == 2'b00));
      ackv = irq_ack && m_req;
      av   = m_vec;
      alvl = prio[av];
      if (irq_ack && m_req) m_req = 0;
      else begin m_req = take; m_vec = (w < 0) ? 0 : w; end
      if (ackv && auto_clr(av)) m_fl[av] = 0;
      if (wdt_clr) m_fl[7] = 0;
      if (tmr_ovf[0]) m_fl[1] = 1;
      if (tmr_ovf[1]) m_fl[3] = 1;
      if (ser_evt) m_fl[4] = 1;
      if (m_eq[2] && !ext_n[2]) m_fl[5] = 1;
      if (m_eq[3] && !ext_n[3]) m_fl[6] = 1;
      if (wdt_tmo) m_fl[7] = 1;
      if (div_ovf) m_fl[8] = 1;
      if (cmp_res && !m_cq) m_fl[9] = 1;
      for (int j = 0; j < 6; j++)
        if (cid_set[j]) m_cid[j] = 1; else if (cid_clr[j]) m_cid[j] = 0;
      if (irq_ret) begin
        if (m_ins[1]) m_ins[1] = 0; else m_ins[0] = 0;
      end
      if (ackv) m_ins[alvl] = 1;
    end
    m_eq = ext_n;
    m_cq = cmp_res;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_req === m_req, "R13 model irq_req", int'(irq_req), int'(m_req));
      if (m_req) chk(int'(irq_vec) == m_vec, "R4 model irq_vec", int'(irq_vec), m_vec);
      chk(in_svc === m_ins, "R5 model in_svc", int'(in_svc), int'(m_ins));
      chk(cid_flags === m_cid, "R12 model cid_flags", int'(cid_flags), int'(m_cid));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      checks++; errors++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic ack();
    irq_ack = 1; tick(1); irq_ack = 0;
  endtask
  task automatic ret();
    irq_ret = 1; tick(1); irq_ret = 0;
  endtask
  task automatic expect_req(input string tag, input int vec);
    chk(irq_req === 1'b1, tag, int'(irq_req), 1);
    chk(int'(irq_vec) == vec, tag, int'(irq_vec), vec);
  endtask
  task automatic expect_idle(input string tag);
    chk(irq_req === 1'b0, tag, int'(irq_req), 0);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R13 reset state
    chk(irq_req === 1'b0, "R13 reset irq_req", int'(irq_req), 0);
    chk(in_svc === 2'b00, "R13 reset in_svc", int'(in_svc), 0);
    chk(cid_flags === 6'd0, "R13 reset cid_flags", int'(cid_flags), 0);

    // R1 global enable
    en_main = 8'h1F;
    tmr_ovf = 2'b01; tick(1); tmr_ovf = 0;
    tick(2);
    expect_idle("R1 global off");
    en_main = 8'h9F; tick(1);
    expect_req("R1 global on, R4 timer0 vector", 1);
    ack();
    expect_idle("R7 drop after ack");
    chk(in_svc === 2'b01, "R5 low in service", int'(in_svc), 1);
    tick(2);
    expect_idle("R7 timer0 flag cleared");
    ret();
    chk(in_svc === 2'b00, "R6 return", int'(in_svc), 0);
    tick(1);
    expect_idle("R7 nothing after return");

    // R13 latency
    ser_evt = 1; tick(1); ser_evt = 0;
    expect_idle("R13 one edge after event");
    tick(1);
    expect_req("R13 two edges after event", 4);
    ack(); ret(); tick(1);

    // R4 tie order
    tmr_ovf = 2'b10; ser_evt = 1; div_ovf = 1; tick(1);
    tmr_ovf = 0; ser_evt = 0; div_ovf = 0; tick(1);
    expect_req("R4 timer1 first", 3);
    ack(); ret(); tick(1);
    expect_req("R4 serial second", 4);
    ack(); ret(); tick(1);
    expect_req("R4 divider third", 8);
    ack(); ret(); tick(1);

    // R3 and R5 levels
    prio = 11'b1 << 8;
    tmr_ovf = 2'b01; div_ovf = 1; tick(1); tmr_ovf = 0; div_ovf = 0; tick(1);
    expect_req("R3 high divider beats timer0", 8);
    ack();
    chk(in_svc === 2'b10, "R5 high in service", int'(in_svc), 2);
    tick(2);
    expect_idle("R5 low blocked under high");
    ret(); tick(1);
    expect_req("R5 low after high return", 1);
    ack();
    div_ovf = 1; tick(1); div_ovf = 0; tick(1);
    expect_req("R5 high preempts low", 8);
    ack();
    chk(in_svc === 2'b11, "R5 nested", int'(in_svc), 3);
    ret();
    chk(in_svc === 2'b01, "R6 highest released first", int'(in_svc), 1);
    ret();
    chk(in_svc === 2'b00, "R6 low released", int'(in_svc), 0);
    prio = '0; tick(1);

    // R2 individual enable
    en_main = 8'h9D;
    tmr_ovf = 2'b01; tick(1); tmr_ovf = 0; tick(2);
    expect_idle("R2 timer0 disabled");
    en_main = 8'h9F; tick(1);
    expect_req("R2 flag kept while disabled", 1);
    ack(); ret(); tick(1);

    // R8 level external 0
    ext_n[0] = 0; tick(2);
    expect_req("R8 ext0 level", 0);
    ack(); ret(); tick(1);
    expect_req("R8 ext0 retaken", 0);
    ack(); ext_n[0] = 1; ret(); tick(2);
    expect_idle("R8 ext0 released");

    // R9 edge external 2
    ext_n[2] = 0; tick(2);
    expect_req("R9 ext2 falling edge", 5);
    ack(); ret(); tick(2);
    expect_idle("R9 held low no new flag");
    ext_n[2] = 1; tick(2);
    expect_idle("R9 rising edge ignored");
    ext_n[2] = 0; tick(2);
    expect_req("R9 second falling edge", 5);
    ack(); ret(); ext_n[2] = 1; tick(1);

    // R10 comparator rising edge
    cmp_res = 1; tick(2);
    expect_req("R10 comparator rise", 9);
    ack(); ret(); tick(2);
    expect_idle("R10 steady high ignored");
    cmp_res = 0; tick(1); cmp_res = 1; tick(2);
    expect_req("R10 second rise", 9);
    ack(); ret(); cmp_res = 0; tick(1);

    // R11 watchdog
    en_ext = 8'h1F;
    wdt_tmo = 1; tick(1); wdt_tmo = 0; tick(2);
    expect_idle("R11 watchdog disabled");
    en_ext = 8'h3F; tick(1);
    expect_req("R11 watchdog enabled", 7);
    ack(); ret(); tick(1);
    expect_req("R11 flag persists after ack", 7);
    wdt_clr = 1; tick(1); wdt_clr = 0; tick(1);
    expect_idle("R11 cleared by software");

    // R12 caller-ID group
    cid_set = 6'b000101; tick(1); cid_set = 0;
    chk(cid_flags === 6'b000101, "R12 sub-flags set", int'(cid_flags), 5);
    tick(1);
    expect_req("R12 caller-ID request", 10);
    ack(); ret(); tick(1);
    expect_req("R12 not cleared by ack", 10);
    chk(cid_flags === 6'b000101, "R12 flags kept", int'(cid_flags), 5);
    cid_clr = 6'b000001; tick(1); cid_clr = 0;
    chk(cid_flags === 6'b000100, "R12 software clear", int'(cid_flags), 4);
    cid_set = 6'b000100; cid_clr = 6'b000100; tick(1); cid_set = 0; cid_clr = 0;
    chk(cid_flags === 6'b000100, "R12 set wins", int'(cid_flags), 4);
    cid_clr = 6'b000100; tick(1); cid_clr = 0; tick(1);
    chk(cid_flags === 6'b000000, "R12 all clear", int'(cid_flags), 0);
    expect_idle("R12 request gone");

    tick(4);
    finish_run();
  end
endmodule